// File: doc/BRIEF.md
# Transition-Minimised Parallel Link Transmitter

This block is the sending side of a narrow source-synchronous chip-to-chip link. Each transaction takes one 18-bit framed word and a one-bit type flag that marks the word as data or control. The word is cut into two 9-bit halves. Each half is bus-inverted on its own: it is complemented when more than half of its bits are set, and a tenth flag bit records whether that happened. The two 10-bit codes leave the block over a 5-bit lane in four consecutive slots. The lane is NRZI coded, so each slot can only flip a line and never drives a level directly.

Two strobe outputs mark the slots. Strobe A follows a fixed high-high-low-low shape over a transaction. Strobe B runs a quarter period away from it, and the block inverts B for control transactions. The type flag therefore travels in the phase relation between the two strobes and uses no lane wire. A link-reset pattern can also be sent: strobe B stays still while strobe A completes one full period. After the pattern, the NRZI line state is zero, so the receiver and the transmitter restart from a known level. One direction of the link therefore uses seven wires.

The block accepts words through a valid/ready handshake. It can send one word every four clock cycles with no gap between transactions.

Top module: `qlink_tx`

## Requirements
- R1: Half A is `in_word[8:0]` and half B is `in_word[17:9]`. Each 10-bit code carries the 9 coded data bits in `[8:0]` and the inversion flag in bit `[9]`.
- R2: A half with more than 4 set bits is sent complemented with its flag at 1. Any other half is sent unchanged with its flag at 0. A boundary half with exactly 5 set bits is complemented, and one with exactly 4 is not.
- R3: The slot order within a transaction is code A `[4:0]`, code A `[9:5]`, code B `[4:0]`, code B `[9:5]`.
- R4: `lane` is NRZI coded. In each slot, every lane bit is its previous level XOR the slot bit.
- R5: Across slots 0..3 of a transaction, `stb_a` is 1,1,0,0. `stb_b` is 0,1,1,0 when `in_ctrl` was 0 and 1,0,0,1 when it was 1. Exactly one strobe changes at each slot boundary inside a transaction.
- R6: A word is taken at a rising edge where `in_valid` and `in_ready` are both 1, and its slot 0 appears right after that edge. `in_ready` is 1 while idle or during slot 3 and 0 in slots 0 to 2. A word offered while `in_ready` is 0 is ignored.
- R7: A word taken during slot 3 starts its slot 0 in the very next cycle, with no idle cycle in between.
- R8: With nothing to send, `lane`, `stb_a` and `stb_b` hold their levels.
- R9: A `link_rst_req` seen while `in_ready` would otherwise be 1 starts the reset pattern, and it takes priority over a valid word, which is not taken. `in_ready` is 0 while `link_rst_req` is 1. For four cycles `stb_a` is 1,1,0,0 while `stb_b` and `lane` hold. After the pattern, all five lane bits are 0.
- R10: While `rst_n` is low, `lane` is 0, both strobes are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A word is offered |
| in_ready | output | 1 | The block can take a word or a reset request this cycle |
| in_word | input | 18 | Framed word to send |
| in_ctrl | input | 1 | 1 marks the word as control, 0 as data |
| link_rst_req | input | 1 | Request to send the link-reset pattern |
| lane | output | 5 | NRZI-coded data lines |
| stb_a | output | 1 | Slot strobe A |
| stb_b | output | 1 | Slot strobe B, a quarter period from A; its polarity carries the type |

## Verification
A slot counter that drifts shows in the same cycle as two strobe edges in one slot, or as a strobe B edge during the reset pattern. An NRZI register that was not cleared, or that picked up a stray update, gives a wrong `lane` level in the very next slot and every slot after it, so the bench tracks the line level across transactions and reset patterns. An inversion decision taken on the wrong half, or at the wrong threshold, shows at the lane as a toggle count that the boundary words with four and five set bits tell apart. A handshake that fires while busy shows as an extra transaction right after the current one.

// File: rtl/qlink_pkg.sv
package qlink_pkg;

  // A transaction always spans one quadrature strobe period: four slots.
  localparam int QL_SLOTS = 4;
  localparam int QL_IDX_W = $clog2(QL_SLOTS);
  localparam logic [QL_IDX_W-1:0] QL_LAST = QL_IDX_W'(QL_SLOTS - 1);

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SEND   = 2'd1,
    ST_RESYNC = 2'd2
  } qlink_state_e;

  // Strobe A: high in the first half of the period.
  function automatic logic stb_a_level(input logic [QL_IDX_W-1:0] slot);
    return (slot < QL_IDX_W'(QL_SLOTS / 2));
  endfunction

  // Strobe B: a quarter period behind A, inverted for control words.
  function automatic logic stb_b_level(input logic [QL_IDX_W-1:0] slot,
                                       input logic ctrl);
    return (slot[1] ^ slot[0]) ^ ctrl;
  endfunction

endpackage

// File: rtl/qlink_inv_enc.sv
module qlink_inv_enc #(
  parameter int HALF_W = 9
) (
  input  logic [HALF_W-1:0] half_in,
  output logic [HALF_W:0]   code_out
);

  function automatic int unsigned ones_in(input logic [HALF_W-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < HALF_W; i++) n += int'(v[i]);
    return n;
  endfunction

  logic invert;

  assign invert   = (ones_in(half_in) > (HALF_W / 2));
  assign code_out = {invert, half_in ^ {HALF_W{invert}}};

endmodule

// File: rtl/qlink_slot_mux.sv
module qlink_slot_mux
  import qlink_pkg::*;
#(
  parameter int SLOT_W = 5
) (
  input  logic [QL_SLOTS*SLOT_W-1:0] line_in,
  input  logic [QL_IDX_W-1:0]        slot_sel,
  output logic [SLOT_W-1:0]          bits_out
);

  logic [SLOT_W-1:0] slot_bits [QL_SLOTS];

  for (genvar s = 0; s < QL_SLOTS; s++) begin : g_slot
    assign slot_bits[s] = line_in[s*SLOT_W +: SLOT_W];
  end

  assign bits_out = slot_bits[slot_sel];

endmodule

// File: rtl/qlink_nrzi.sv
module qlink_nrzi #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              clr,
  input  logic [SLOT_W-1:0] bits,
  output logic [SLOT_W-1:0] lane
);

  logic [SLOT_W-1:0] base;

  // After a reset pattern the new transaction starts from all-zero lines.
  assign base = clr ? '0 : lane;

  always_ff @(posedge clk) begin
    if (!rst_n)       lane <= '0;
    else if (upd)     lane <= base ^ bits;
    else if (clr)     lane <= '0;
  end

  AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd && !clr) |=> $stable(lane)); // R8

  AST_LANE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !upd) |=> (lane == '0)); // R9

endmodule

// File: rtl/qlink_seq.sv
module qlink_seq
  import qlink_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_ctrl,
  input  logic                link_rst_req,
  output logic                in_ready,
  output logic                accept_evt,
  output logic                step_evt,
  output logic                clear_evt,
  output logic                send_active,
  output logic [QL_IDX_W-1:0] slot_nxt,
  output logic                stb_a,
  output logic                stb_b
);

  qlink_state_e        state_q;
  logic [QL_IDX_W-1:0] slot_q;
  logic [QL_IDX_W-1:0] slot_inc;
  logic                ctrl_q;
  logic                at_last;
  logic                slot_free;
  logic                rst_start_evt;
  logic                rs_step_evt;

  assign at_last       = (slot_q == QL_LAST);
  assign slot_free     = (state_q == ST_IDLE) || at_last;
  assign rst_start_evt = slot_free && link_rst_req;
  assign accept_evt    = slot_free && !link_rst_req && in_valid;
  assign in_ready      = slot_free && !link_rst_req;
  assign step_evt      = (state_q == ST_SEND) && !at_last;
  assign rs_step_evt   = (state_q == ST_RESYNC) && !at_last;
  assign clear_evt     = (state_q == ST_RESYNC) && at_last;
  assign send_active   = (state_q == ST_SEND);
  assign slot_inc      = slot_q + 1'b1;
  assign slot_nxt      = accept_evt ? '0 : slot_inc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
      ctrl_q  <= 1'b0;
      stb_a   <= 1'b0;
      stb_b   <= 1'b0;
    end else if (rst_start_evt) begin
      state_q <= ST_RESYNC;
      slot_q  <= '0;
      stb_a   <= stb_a_level('0);
    end else if (accept_evt) begin
      state_q <= ST_SEND;
      slot_q  <= '0;
      ctrl_q  <= in_ctrl;
      stb_a   <= stb_a_level('0);
      stb_b   <= stb_b_level('0, in_ctrl);
    end else if (step_evt) begin
      slot_q  <= slot_inc;
      stb_a   <= stb_a_level(slot_inc);
      stb_b   <= stb_b_level(slot_inc, ctrl_q);
    end else if (rs_step_evt) begin
      slot_q  <= slot_inc;
      stb_a   <= stb_a_level(slot_inc);
    end else if (slot_free) begin
      state_q <= ST_IDLE;
      slot_q  <= '0;
    end
  end

  AST_ONE_STROBE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SEND && slot_q != '0) |->
      ($countones({stb_a, stb_b} ^ {$past(stb_a), $past(stb_b)}) == 1)); // R5

  AST_RESYNC_B_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESYNC) |-> $stable(stb_b)); // R9

  AST_ACCEPT_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (state_q == ST_SEND && slot_q == '0 && stb_a)); // R6

endmodule

// File: rtl/qlink_tx.sv
module qlink_tx
  import qlink_pkg::*;
#(
  parameter int HALF_W = 9,
  parameter int SLOT_W = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*HALF_W-1:0]   in_word,
  input  logic                  in_ctrl,
  input  logic                  link_rst_req,
  output logic [SLOT_W-1:0]     lane,
  output logic                  stb_a,
  output logic                  stb_b
);

  localparam int CODE_W = HALF_W + 1;
  localparam int LINE_W = 2 * CODE_W;

  if (LINE_W != QL_SLOTS * SLOT_W) begin : g_width_check
    $error("two coded halves must fill exactly four lane slots");
  end

  logic [LINE_W-1:0]   code_fresh;
  logic [LINE_W-1:0]   code_q;
  logic [LINE_W-1:0]   code_src;
  logic [SLOT_W-1:0]   slot_bits;
  logic [QL_IDX_W-1:0] slot_nxt;
  logic                accept_evt;
  logic                step_evt;
  logic                clear_evt;
  logic                send_active;

  // One inversion encoder per half: half A is the low half.
  for (genvar h = 0; h < 2; h++) begin : g_half
    qlink_inv_enc #(.HALF_W(HALF_W)) u_enc (
      .half_in  (in_word[h*HALF_W +: HALF_W]),
      .code_out (code_fresh[h*CODE_W +: CODE_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          code_q <= '0;
    else if (accept_evt) code_q <= code_fresh;
  end

  // Slot 0 leaves on the accepting edge, so it reads the fresh codes.
  assign code_src = accept_evt ? code_fresh : code_q;

  qlink_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ctrl      (in_ctrl),
    .link_rst_req (link_rst_req),
    .in_ready     (in_ready),
    .accept_evt   (accept_evt),
    .step_evt     (step_evt),
    .clear_evt    (clear_evt),
    .send_active  (send_active),
    .slot_nxt     (slot_nxt),
    .stb_a        (stb_a),
    .stb_b        (stb_b)
  );

  qlink_slot_mux #(.SLOT_W(SLOT_W)) u_mux (
    .line_in  (code_src),
    .slot_sel (slot_nxt),
    .bits_out (slot_bits)
  );

  qlink_nrzi #(.SLOT_W(SLOT_W)) u_nrzi (
    .clk   (clk),
    .rst_n (rst_n),
    .upd   (accept_evt || step_evt),
    .clr   (clear_evt),
    .bits  (slot_bits),
    .lane  (lane)
  );

  AST_CODE_WEIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    send_active |->
      (($countones(code_q[CODE_W-2:0]) <= HALF_W / 2) &&
       ($countones(code_q[LINE_W-2:CODE_W]) <= HALF_W / 2))); // R2

endmodule

// File: tb/qlink_tx_tb.sv
`timescale 1ns/1ps
module qlink_tx_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_word = '0;
  logic        in_ctrl = 1'b0;
  logic        link_rst_req = 1'b0;
  logic [4:0]  lane;
  logic        stb_a;
  logic        stb_b;

  int checks = 0;
  int fails  = 0;
  logic [4:0] lane_m = '0;

  always #2 clk = ~clk;

  qlink_tx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_ctrl(in_ctrl), .link_rst_req(link_rst_req),
    .lane(lane), .stb_a(stb_a), .stb_b(stb_b)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [9:0] enc_ref(input logic [8:0] h);
    int ones = 0;
    foreach (h[i]) if (h[i]) ones++;
    if (ones >= 5) return {1'b1, ~h};
    return {1'b0, h};
  endfunction

  function automatic logic [4:0] slot_ref(input logic [17:0] w, input int s);
    logic [9:0] ca = enc_ref(w[8:0]);
    logic [9:0] cb = enc_ref(w[17:9]);
    case (s)
      0: return ca[4:0];
      1: return ca[9:5];
      2: return cb[4:0];
      default: return cb[9:5];
    endcase
  endfunction

  // Offer a word at a negedge while in_ready is high; returns at slot 0.
  task automatic start_word(input logic [17:0] w, input logic c);
    in_word = w; in_ctrl = c; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // Check the four slots of a transaction; optionally offer junk while busy.
  task automatic check_slots(input logic [17:0] w, input logic c,
                             input bit hold, input string tag);
    for (int s = 0; s < 4; s++) begin
      if (s > 0) @(negedge clk);
      if (hold) begin
        in_word = ~w; in_ctrl = ~c; in_valid = (s < 3);
      end
      lane_m = lane_m ^ slot_ref(w, s);
      chk("R3/R4", {tag, " lane"}, lane, lane_m);
      chk("R5", {tag, " stb_a"}, stb_a, (s < 2));
      chk("R5", {tag, " stb_b"}, stb_b, ((s == 1 || s == 2) ? 1'b1 : 1'b0) ^ c);
      if (s < 3) chk("R6", {tag, " ready low while busy"}, in_ready, 1'b0);
      else       chk("R6", {tag, " ready in slot 3"}, in_ready, 1'b1);
    end
  endtask

  task automatic check_idle(input int n, input string tag);
    logic a0 = stb_a;
    logic b0 = stb_b;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R8", {tag, " lane hold"}, lane, lane_m);
      chk("R8", {tag, " strobes hold"}, {stb_a, stb_b}, {a0, b0});
    end
  endtask

  task automatic test_reset_state;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10", "lane in reset", lane, 5'd0);
    chk("R10", "strobes in reset", {stb_a, stb_b}, 2'b00);
    chk("R10", "ready in reset", in_ready, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    lane_m = '0;
  endtask

  task automatic test_data_word;
    // A = 0x00F (4 ones, kept), B = 0x1FF (9 ones, inverted): R1 R2
    logic [17:0] w = {9'h1FF, 9'h00F};
    start_word(w, 1'b0);
    chk("R1", "slot0 carries half A low bits", lane, 5'h0F);
    check_slots(w, 1'b0, 1'b0, "data");
    check_idle(3, "after data");
  endtask

  task automatic test_ctrl_boundary;
    // A = 0x01F and B = 0x155 have exactly 5 ones: both inverted (R2)
    logic [17:0] w = {9'h155, 9'h01F};
    logic [4:0]  l0 = lane_m;
    start_word(w, 1'b1);
    chk("R2", "5-ones half inverted, slot0", lane, l0 ^ 5'h00);
    check_slots(w, 1'b1, 1'b0, "ctrl");
    check_idle(2, "after ctrl");
  endtask

  task automatic test_back_to_back;
    logic [17:0] w3 = 18'h2A5C3;
    logic [17:0] w4 = 18'h12345;
    start_word(w3, 1'b0);
    check_slots(w3, 1'b0, 1'b0, "b2b first");
    start_word(w4, 1'b1);   // taken at the end of slot 3: R7
    check_slots(w4, 1'b1, 1'b0, "R7 b2b second");
    check_idle(2, "after b2b");
  endtask

  task automatic test_busy_ignored;
    logic [17:0] w = 18'h0F0F0;
    start_word(w, 1'b0);
    check_slots(w, 1'b0, 1'b1, "busy");
    check_idle(3, "R6 junk ignored");
  endtask

  task automatic test_link_reset(input bit with_valid, input string tag);
    logic b0 = stb_b;
    link_rst_req = 1'b1;
    if (with_valid) begin
      in_word = 18'h3FFFF; in_ctrl = 1'b0; in_valid = 1'b1;
    end
    #0;
    chk("R9", {tag, " ready low on request"}, in_ready, 1'b0);
    @(negedge clk);
    link_rst_req = 1'b0; in_valid = 1'b0;
    for (int s = 0; s < 4; s++) begin
      if (s > 0) @(negedge clk);
      chk("R9", {tag, " stb_a period"}, stb_a, (s < 2));
      chk("R9", {tag, " stb_b still"}, stb_b, b0);
      chk("R9", {tag, " lane held"}, lane, lane_m);
    end
    @(negedge clk);
    lane_m = '0;
    chk("R9", {tag, " lane cleared"}, lane, 5'd0);
    chk("R9", {tag, " strobes after"}, {stb_a, stb_b}, {1'b0, b0});
    check_idle(2, {tag, " no word taken"});
  endtask

  task automatic test_after_reset_word;
    logic [17:0] w = 18'h0B6D9;
    start_word(w, 1'b0);
    chk("R4", "first slot after reset from zero", lane, slot_ref(w, 0));
    check_slots(w, 1'b0, 1'b0, "post-reset");
  endtask

  initial begin
    test_reset_state();
    test_data_word();
    test_ctrl_boundary();
    test_back_to_back();
    test_busy_ignored();
    test_link_reset(1'b0, "R9 pattern");
    test_after_reset_word();
    check_idle(1, "settle");
    test_link_reset(1'b1, "R9 priority");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule